// File: doc/BRIEF.md
# Idle-Run Mute Controller

This block sits in the bit-clock domain of an audio converter and decides, cycle by cycle, whether the modulator output passes to the output stage or is replaced by the mid-scale (bipolar zero) level. It watches a per-bit-clock flag that says whether the current input data is zero. It counts how many such zero cycles arrive in a row. When the run reaches a long threshold of bit clocks (65,536 by default), it reports an idle condition. If automatic muting is enabled, it then forces the output to mid-scale.

Two controls override the automatic decision, in a fixed order. The active-low reset always forces mid-scale and holds the run counter cleared. After reset comes the output-enable control, which forces mid-scale whatever the data. After that comes the idle detection, gated by its enable bit. In every other case the data is converted normally. Whenever the output is forced, the modulator-connect flag drops so the modulator is cut off from the output stage. The analog mid-scale level itself is produced elsewhere.

Top module: `idle_mute_ctrl`

## Requirements
- R1: While `rstN` is low, `forceMid` is 1, `modConnect` is 0 and `zeroSeen` is 0. Zero cycles sampled during reset are not counted, so counting starts fresh after release.
- R2: With `rstN` high, `zeroSeen` becomes 1 right after the ZERO_RUN-th consecutive rising edge that samples `dataZero`=1. It is still 0 after ZERO_RUN-1 such edges.
- R3: With `rstN`=1, `outEnable`=0 and `zeroDetEn`=1, `forceMid` follows `zeroSeen` in the same cycle, with no added register.
- R4: With `zeroDetEn`=0, `forceMid` stays 0 even while `zeroSeen` is 1, and `modConnect` stays 1.
- R5: With `rstN`=1 and `outEnable`=1, `forceMid` is 1 whatever `dataZero`, `zeroSeen` or `zeroDetEn` are.
- R6: A rising edge that samples `dataZero`=0 clears the run. `zeroSeen` and any idle forcing drop after that edge, and a new detection needs a full ZERO_RUN zero edges again.
- R7: Once the threshold is reached, further zero edges keep `zeroSeen` at 1; the count saturates and does not wrap.
- R8: `modConnect` is always the inverse of `forceMid`.
- R9: With `rstN`=1, `outEnable`=0 and a run below threshold, `forceMid` is 0 for either value of `zeroDetEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low reset; forces mid-scale and clears the run (asynchronous assert) |
| dataZero | input | 1 | 1 when the input data of this bit clock is zero |
| outEnable | input | 1 | 1 forces mid-scale regardless of data |
| zeroDetEn | input | 1 | 1 lets a detected idle run force mid-scale |
| forceMid | output | 1 | 1 when the output is held at bipolar zero |
| zeroSeen | output | 1 | 1 while the current zero run has reached the threshold |
| modConnect | output | 1 | 1 when the modulator drives the output stage |

## Verification
Two functions can land in the same cycle: the idle run reaching its threshold and a manual override (output enable, or the enable bit being switched off) that acts on the same output. The bench drives a full-length zero run until `zeroSeen` rises, then toggles `outEnable` and `zeroDetEn` while the run stays saturated. It judges `forceMid` and `modConnect` against the priority order in each combination. A non-zero sample then ends the forcing on the very next edge, and a nearly full second run confirms that the count truly restarted.

// File: rtl/zmc_pkg.sv
package zmc_pkg;

  // Strobes from control to the run counter
  typedef struct packed {
    logic clr;   // clear the zero run
    logic inc;   // one more zero bit clock
  } cntStrobe_t;

  // Which rule currently decides the output
  typedef enum logic [1:0] {
    OUT_PASS      = 2'd0,
    OUT_RST_FORCE = 2'd1,
    OUT_OE_FORCE  = 2'd2,
    OUT_ZD_FORCE  = 2'd3
  } outCause_t;

endpackage

// File: rtl/zmc_run_counter.sv
module zmc_run_counter
  import zmc_pkg::*;
#(
  parameter int ZERO_RUN = 65536
) (
  input  logic       clk,
  input  logic       rstN,
  input  cntStrobe_t strobe,
  output logic       atLimit
);

  localparam int CW = $clog2(ZERO_RUN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(ZERO_RUN);

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (strobe.clr) begin
      runCnt <= '0;
    end else if (strobe.inc && (runCnt != LIMIT)) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  assign atLimit = (runCnt == LIMIT);

  // R6: a clear strobe empties the run on the next edge
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (runCnt == '0));

  // R7: at the threshold, more zeros keep the count saturated
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (atLimit && strobe.inc && !strobe.clr) |=> atLimit);

  // R2: below the threshold each zero adds exactly one
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && !strobe.clr && !atLimit) |=> (runCnt == $past(runCnt) + 1'b1));

endmodule

// File: rtl/zmc_ctrl.sv
module zmc_ctrl
  import zmc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataZero,
  input  logic       outEnable,
  input  logic       zeroDetEn,
  input  logic       zeroSeenIn,
  output cntStrobe_t strobe,
  output logic       forceMid,
  output logic       modConnect
);

  outCause_t cause;

  // Counter strobes: hold cleared in reset, clear on data, count zeros
  always_comb begin
    strobe.clr = !rstN || !dataZero;
    strobe.inc = rstN && dataZero;
  end

  // Fixed priority: reset, output enable, idle detection, pass
  always_comb begin
    if (!rstN)                       cause = OUT_RST_FORCE;
    else if (outEnable)              cause = OUT_OE_FORCE;
    else if (zeroDetEn && zeroSeenIn) cause = OUT_ZD_FORCE;
    else                             cause = OUT_PASS;
  end

  assign forceMid   = (cause != OUT_PASS);
  assign modConnect = (cause == OUT_PASS);

  // R6: a non-zero sample ends the detected idle state at the next edge
  assert_data_ends_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!dataZero) |=> !zeroSeenIn);

  // R2: the idle state only begins after an edge that sampled zero data
  assert_idle_needs_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(zeroSeenIn) |-> $past(dataZero));

endmodule

// File: rtl/idle_mute_ctrl.sv
module idle_mute_ctrl
  import zmc_pkg::*;
#(
  parameter int ZERO_RUN = 65536
) (
  input  logic clk,
  input  logic rstN,
  input  logic dataZero,
  input  logic outEnable,
  input  logic zeroDetEn,
  output logic forceMid,
  output logic zeroSeen,
  output logic modConnect
);

  cntStrobe_t strobe;
  logic       atLimit;

  zmc_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .dataZero   (dataZero),
    .outEnable  (outEnable),
    .zeroDetEn  (zeroDetEn),
    .zeroSeenIn (atLimit),
    .strobe     (strobe),
    .forceMid   (forceMid),
    .modConnect (modConnect)
  );

  zmc_run_counter #(.ZERO_RUN(ZERO_RUN)) uRun (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .atLimit (atLimit)
  );

  assign zeroSeen = atLimit;

endmodule

// File: tb/tb_idle_mute_ctrl.sv
module tb_idle_mute_ctrl;

  localparam int N = 65536;

  logic clk = 1'b0;
  logic rstN, dataZero, outEnable, zeroDetEn;
  logic forceMid, zeroSeen, modConnect;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  idle_mute_ctrl #(.ZERO_RUN(N)) dut (
    .clk(clk), .rstN(rstN), .dataZero(dataZero), .outEnable(outEnable),
    .zeroDetEn(zeroDetEn), .forceMid(forceMid), .zeroSeen(zeroSeen),
    .modConnect(modConnect)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  // check all three outputs, plus R8 inverse relation
  task automatic chkOut(input string req, input logic expForce, input logic expSeen);
    chk(req, "forceMid", forceMid, expForce);
    chk(req, "zeroSeen", zeroSeen, expSeen);
    chk("R8", "modConnect", modConnect, ~expForce);
  endtask

  // advance one rising edge, inputs change 1 ns after it
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic testReset();
    rstN = 0; dataZero = 1; outEnable = 0; zeroDetEn = 1;
    tick(20);
    chkOut("R1", 1'b1, 1'b0);
  endtask

  task automatic testDetect();
    rstN = 1;
    tick(N - 1);
    chkOut("R2", 1'b0, 1'b0);
    tick(1);
    chkOut("R3", 1'b1, 1'b1);
  endtask

  task automatic testSaturate();
    tick(200);
    chkOut("R7", 1'b1, 1'b1);
  endtask

  task automatic testOverrides();
    zeroDetEn = 0; #1;
    chkOut("R4", 1'b0, 1'b1);
    tick(3);
    chkOut("R4", 1'b0, 1'b1);
    outEnable = 1; #1;
    chkOut("R5", 1'b1, 1'b1);
    zeroDetEn = 1; #1;
    chkOut("R5", 1'b1, 1'b1);
    outEnable = 0; #1;
    chkOut("R3", 1'b1, 1'b1);
  endtask

  task automatic testDataClears();
    dataZero = 0; #1;
    chkOut("R6", 1'b1, 1'b1);   // not yet sampled
    tick(1);
    chkOut("R6", 1'b0, 1'b0);
    zeroDetEn = 0; #1;
    chkOut("R9", 1'b0, 1'b0);
    zeroDetEn = 1; tick(5);
    chkOut("R9", 1'b0, 1'b0);
    outEnable = 1; #1;
    chkOut("R5", 1'b1, 1'b0);
    outEnable = 0;
  endtask

  task automatic testRestart();
    dataZero = 1;
    tick(N - 1);
    chkOut("R6", 1'b0, 1'b0);
    dataZero = 0; tick(1);
    dataZero = 1; tick(10);
    chkOut("R9", 1'b0, 1'b0);
  endtask

  task automatic testResetMidRun();
    rstN = 0; #1;
    chkOut("R1", 1'b1, 1'b0);
    tick(3);
    rstN = 1;
    tick(N - 1);
    chkOut("R1", 1'b0, 1'b0);
    tick(1);
    chkOut("R2", 1'b1, 1'b1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testDetect();
    testSaturate();
    testOverrides();
    testDataClears();
    testRestart();
    testResetMidRun();
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

endmodule